// File: doc/BRIEF.md
# 16-bit Timer/Counter with Clear-on-Compare

This block is a 16-bit up-counter with one compare channel and one compare output pin. A 4-bit mode field chooses how the counter wraps. In free-running mode it rolls over from all ones to zero. In the two clear-on-compare modes it restarts from zero after reaching a top value. That top value is taken either from compare register A or from the capture register.

On a compare match the output pin follows a 2-bit action field. A strobe lets software apply the same action at once, without waiting for a match. A sticky overflow flag and a sticky compare flag are cleared only by their acknowledge inputs. The counter advances only in cycles where the timer-clock enable is high.

Software reaches the block through a plain write port and a registered read port. Address 0 is the counter, 1 is compare A, 2 is the capture register and 3 is control. In the control word, bits [3:0] hold the mode, bits [5:4] hold the pin action, and bit 8 is the force strobe, which always reads back as zero.

Top module: `tmr16_ctc`

## Requirements
- R1: With mode 0, the counter counts up through a value equal to compare A without being cleared.
- R2: With mode 0, the counter steps from 0xFFFF to 0x0000 on the next enabled cycle.
- R3: The overflow flag rises on the same clock edge at which the counter wraps from 0xFFFF to 0x0000.
- R4: Only hardware sets the overflow flag. It stays set until an overflow acknowledge arrives, and the acknowledge clears it.
- R5: With mode 4, compare A is the top. The counter counts up to compare A, and the next enabled cycle loads 0.
- R6: An enabled cycle in which the counter equals compare A sets the compare flag. The flag stays set until a compare acknowledge arrives.
- R7: With mode 12, the capture register is the top. The counter counts up to the capture value and then loads 0, whatever the value of compare A.
- R8: On a compare match the pin follows the action field: 0 leaves it unchanged, 1 toggles it, 2 drives it low, 3 drives it high.
- R9: Writing a new action field does not change the pin. The new action is used from the next compare match onward.
- R10: Writing control with bit 8 set applies the action in that same write to the pin immediately. It does not set the compare flag and does not change the counter.
- R11: The counter holds its value in every cycle where the timer-clock enable is low.
- R12: Any mode code other than 0, 4 and 12 behaves as mode 0.
- R13: Software may write the counter at any time. A write takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer-clock enable; the counter advances on edges where this is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 counter, 1 compare A, 2 capture, 3 control) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 16 | Read data, registered one cycle after rd_addr |
| ack_ovf | input | 1 | Overflow interrupt acknowledge; clears the overflow flag |
| ack_cmp | input | 1 | Compare interrupt acknowledge; clears the compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| oc_pin | output | 1 | Compare output pin |

## Verification
The wrap point is tested three ways. Mode 0 runs past a value equal to compare A, mode 4 restarts at compare A, and mode 12 restarts at the capture value while compare A is set far away. A top taken from the wrong source shows up as a counter value that does not match. A run from 0xFFFD checks when the overflow flag rises. Further runs with the enable low, with acknowledges withheld and then given, and with an unused mode code separate holding, stickiness and fallback. The pin is driven through each action code, then by a bare action write, and then by a forced write. These steps show whether the action is taken at a match, at the write, or only at the force strobe.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam logic [3:0] MODE_FREE  = 4'd0;
  localparam logic [3:0] MODE_TOP_A = 4'd4;
  localparam logic [3:0] MODE_TOP_I = 4'd12;

  typedef enum logic [1:0] {
    OC_NONE   = 2'd0,
    OC_TOGGLE = 2'd1,
    OC_LOW    = 2'd2,
    OC_HIGH   = 2'd3
  } oc_act_e;

  localparam logic [1:0] ADR_CNT  = 2'd0;
  localparam logic [1:0] ADR_CMPA = 2'd1;
  localparam logic [1:0] ADR_CAPT = 2'd2;
  localparam logic [1:0] ADR_CTRL = 2'd3;
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int W      = 16,
  parameter int AW     = 2,
  parameter int MODE_W = 4,
  parameter int FRC_B  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic [W-1:0]      cnt,
  output logic [W-1:0]      rd_data,
  output logic [W-1:0]      cmpa,
  output logic [W-1:0]      capt,
  output logic [MODE_W-1:0] mode,
  output oc_act_e           com,
  output logic              cnt_wr,
  output logic              frc,
  output oc_act_e           frc_com
);
  localparam int COM_LO = MODE_W;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == AW'(ADR_CTRL));
  assign cnt_wr  = wr_en && (wr_addr == AW'(ADR_CNT));
  assign frc     = ctrl_wr && wr_data[FRC_B];
  assign frc_com = oc_act_e'(wr_data[COM_LO+1:COM_LO]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpa <= '0;
      capt <= '0;
      mode <= '0;
      com  <= OC_NONE;
    end else if (wr_en) begin
      if (wr_addr == AW'(ADR_CMPA)) cmpa <= wr_data;
      if (wr_addr == AW'(ADR_CAPT)) capt <= wr_data;
      if (ctrl_wr) begin
        mode <= wr_data[MODE_W-1:0];
        com  <= oc_act_e'(wr_data[COM_LO+1:COM_LO]);
      end
    end
  end

  logic [W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      AW'(ADR_CNT):  rd_mux = cnt;
      AW'(ADR_CMPA): rd_mux = cmpa;
      AW'(ADR_CAPT): rd_mux = capt;
      default: begin
        rd_mux[MODE_W-1:0]       = mode;
        rd_mux[COM_LO+1:COM_LO]  = com;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/tmr16_count.sv
module tmr16_count
  import tmr16_pkg::*;
#(
  parameter int W      = 16,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [MODE_W-1:0] mode,
  input  logic [W-1:0]      cmpa,
  input  logic [W-1:0]      capt,
  input  logic              cnt_wr,
  input  logic [W-1:0]      cnt_wdata,
  input  logic              ack_ovf,
  input  logic              ack_cmp,
  output logic [W-1:0]      cnt,
  output logic              match,
  output logic              ovf_flag,
  output logic              cmp_flag
);
  localparam logic [W-1:0] MAXV = '1;

  logic         clr_mode;
  logic [W-1:0] top;
  logic         step;
  logic         wrap;

  always_comb begin
    clr_mode = 1'b1;
    top      = MAXV;
    case (mode)
      MODE_W'(MODE_TOP_A): top = cmpa;
      MODE_W'(MODE_TOP_I): top = capt;
      default:             clr_mode = 1'b0;
    endcase
  end

  assign step  = tick && !cnt_wr;
  assign match = step && (cnt == cmpa);
  assign wrap  = step && (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (cnt_wr)                        cnt <= cnt_wdata;
      else if (step && clr_mode && cnt == top) cnt <= '0;
      else if (step)                     cnt <= cnt + 1'b1;

      if (wrap)         ovf_flag <= 1'b1;
      else if (ack_ovf) ovf_flag <= 1'b0;

      if (match)        cmp_flag <= 1'b1;
      else if (ack_cmp) cmp_flag <= 1'b0;
    end
  end

  // R4: flag is sticky until acknowledged
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ack_ovf) |=> ovf_flag);
  // R3: flag rises only together with the counter reaching zero
  a_r3_ovf_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> (cnt == '0));
  // R11: counter holds without the enable or a write
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> $stable(cnt));
  // R5: mode 4 restarts at compare A
  a_r5_top_a: assert property (@(posedge clk) disable iff (rst)
    (step && mode == MODE_W'(MODE_TOP_A) && cnt == cmpa) |=> (cnt == '0));
  // R6: compare flag sticky until acknowledged
  a_r6_cmp_sticky: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !ack_cmp) |=> cmp_flag);
endmodule

// File: rtl/tmr16_ocunit.sv
module tmr16_ocunit
  import tmr16_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    match,
  input  oc_act_e com,
  input  logic    frc,
  input  oc_act_e frc_com,
  output logic    oc_pin
);
  logic    fire;
  oc_act_e act;

  assign fire = frc || match;
  assign act  = frc ? frc_com : com;

  always_ff @(posedge clk) begin
    if (rst) oc_pin <= 1'b0;
    else if (fire) begin
      case (act)
        OC_TOGGLE: oc_pin <= ~oc_pin;
        OC_LOW:    oc_pin <= 1'b0;
        OC_HIGH:   oc_pin <= 1'b1;
        default:   oc_pin <= oc_pin;
      endcase
    end
  end

  // R9: without a match or force the pin never moves
  a_r9_pin_quiet: assert property (@(posedge clk) disable iff (rst)
    (!match && !frc) |=> $stable(oc_pin));
  // R10: a forced high drives the pin high
  a_r10_force_high: assert property (@(posedge clk) disable iff (rst)
    (frc && frc_com == OC_HIGH) |=> oc_pin);
endmodule

// File: rtl/tmr16_ctc.sv
module tmr16_ctc
  import tmr16_pkg::*;
#(
  parameter int W      = 16,
  parameter int AW     = 2,
  parameter int MODE_W = 4,
  parameter int FRC_B  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          ack_ovf,
  input  logic          ack_cmp,
  output logic          ovf_flag,
  output logic          cmp_flag,
  output logic          oc_pin
);
  logic [W-1:0]      cnt, cmpa, capt;
  logic [MODE_W-1:0] mode;
  oc_act_e           com, frc_com;
  logic              cnt_wr, frc, match;

  tmr16_regs #(.W(W), .AW(AW), .MODE_W(MODE_W), .FRC_B(FRC_B)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt(cnt), .rd_data(rd_data), .cmpa(cmpa), .capt(capt),
    .mode(mode), .com(com), .cnt_wr(cnt_wr), .frc(frc), .frc_com(frc_com)
  );

  tmr16_count #(.W(W), .MODE_W(MODE_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .cmpa(cmpa), .capt(capt),
    .cnt_wr(cnt_wr), .cnt_wdata(wr_data), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
    .cnt(cnt), .match(match), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  tmr16_ocunit u_oc (
    .clk(clk), .rst(rst), .match(match), .com(com), .frc(frc),
    .frc_com(frc_com), .oc_pin(oc_pin)
  );

  // R10: a forced compare leaves the compare flag alone
  a_r10_no_flag: assert property (@(posedge clk) disable iff (rst)
    (frc && !tick && !cmp_flag) |=> !cmp_flag);
endmodule

// File: tb/tb_tmr16_ctc.sv
module tb_tmr16_ctc;
  logic        clk = 0, rst = 1, tick = 0, wr_en = 0, ack_ovf = 0, ack_cmp = 0;
  logic [1:0]  wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic        ovf_flag, cmp_flag, oc_pin;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  tmr16_ctc dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); rd_addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic run(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic acks();
    @(negedge clk); ack_ovf = 1; ack_cmp = 1;
    @(negedge clk); ack_ovf = 0; ack_cmp = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v);
    chk("R11 reset counter", v, 16'h0);
    chk("R4 reset ovf", {15'b0, ovf_flag}, 16'h0);
    chk("R8 reset pin", {15'b0, oc_pin}, 16'h0);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    wr(2'd3, 16'h0000);
    wr(2'd0, 16'hFFFD);
    run(2);
    rd(2'd0, v);
    chk("R13 R2 count to FFFF", v, 16'hFFFF);
    chk("R3 no ovf before wrap", {15'b0, ovf_flag}, 16'h0);
    run(1);
    rd(2'd0, v);
    chk("R2 wrap to zero", v, 16'h0000);
    chk("R3 ovf at wrap", {15'b0, ovf_flag}, 16'h1);
    run(5);
    chk("R4 ovf sticky", {15'b0, ovf_flag}, 16'h1);
    acks();
    chk("R4 ack clears ovf", {15'b0, ovf_flag}, 16'h0);
  endtask

  task automatic t_hold();
    logic [15:0] v;
    wr(2'd0, 16'h0042);
    repeat (6) @(negedge clk);
    rd(2'd0, v);
    chk("R11 hold without tick", v, 16'h0042);
  endtask

  task automatic t_free_cmp(input logic [15:0] md, input string req);
    logic [15:0] v;
    wr(2'd1, 16'h0002);
    wr(2'd3, md);
    wr(2'd0, 16'h0000);
    run(5);
    rd(2'd0, v);
    chk(req, v, 16'h0005);
  endtask

  task automatic t_top_a();
    logic [15:0] v;
    acks();
    wr(2'd1, 16'h0005);
    wr(2'd3, 16'h0004);
    wr(2'd0, 16'h0000);
    run(5);
    rd(2'd0, v);
    chk("R5 reach top A", v, 16'h0005);
    chk("R6 no flag before match", {15'b0, cmp_flag}, 16'h0);
    run(1);
    rd(2'd0, v);
    chk("R5 clear after top A", v, 16'h0000);
    chk("R6 flag at match", {15'b0, cmp_flag}, 16'h1);
    run(3);
    chk("R6 flag sticky", {15'b0, cmp_flag}, 16'h1);
    acks();
    chk("R6 ack clears flag", {15'b0, cmp_flag}, 16'h0);
  endtask

  task automatic t_top_i();
    logic [15:0] v;
    wr(2'd1, 16'd100);
    wr(2'd2, 16'h0002);
    wr(2'd3, 16'h000C);
    wr(2'd0, 16'h0000);
    run(2);
    rd(2'd0, v);
    chk("R7 reach capture top", v, 16'h0002);
    run(1);
    rd(2'd0, v);
    chk("R7 clear after capture top", v, 16'h0000);
  endtask

  task automatic t_pin();
    wr(2'd1, 16'h0001);
    wr(2'd3, 16'h0014);          // mode 4, toggle
    wr(2'd0, 16'h0000);
    run(2);
    chk("R8 toggle high", {15'b0, oc_pin}, 16'h1);
    run(2);
    chk("R8 toggle low", {15'b0, oc_pin}, 16'h0);
    wr(2'd3, 16'h0034);          // set action
    chk("R9 action write leaves pin", {15'b0, oc_pin}, 16'h0);
    run(2);
    chk("R8 set on match", {15'b0, oc_pin}, 16'h1);
    wr(2'd3, 16'h0024);          // clear action
    chk("R9 action write leaves pin", {15'b0, oc_pin}, 16'h1);
    run(2);
    chk("R8 clear on match", {15'b0, oc_pin}, 16'h0);
    wr(2'd3, 16'h0004);          // no action
    run(2);
    chk("R8 none on match", {15'b0, oc_pin}, 16'h0);
  endtask

  task automatic t_force();
    logic [15:0] v;
    acks();
    wr(2'd0, 16'h0001);
    wr(2'd3, 16'h0114);          // force with toggle
    chk("R10 force toggles pin", {15'b0, oc_pin}, 16'h1);
    chk("R10 force no flag", {15'b0, cmp_flag}, 16'h0);
    rd(2'd0, v);
    chk("R10 force keeps counter", v, 16'h0001);
    rd(2'd3, v);
    chk("R10 force bit reads zero", v, 16'h0014);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_wrap();
    t_hold();
    t_free_cmp(16'h0000, "R1 mode 0 ignores compare");
    t_free_cmp(16'h0007, "R12 unused mode runs free");
    t_top_a();
    t_top_i();
    t_pin();
    t_force();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule